// File: doc/BRIEF.md
# Bidirectional Latched and Registered Bus Transceiver

This block connects two 18-bit buses, called A and B, through two independent one-way data paths. The A-to-B path drives the B bus from the A inputs. The B-to-A path drives the A bus from the B inputs. Each path has its own storage element, latch-enable level, capture clock and output enable. A path works in one of three ways:

- **Transparent:** while its latch enable is high, the output follows the input with no clock involved.
- **Hold:** while its latch enable is low and its clock does not rise, the stored word stays as it is.
- **Capture:** while its latch enable is low, a rising edge of its clock loads the input.

The two output enables have opposite polarities. The A-to-B enable is active high and the B-to-A enable is active low.

Each bus is modelled as an input vector, an output vector and a drive flag. The drive flag stands in for the high-impedance state. A bus keeper holds the last value the block actively drove whenever the drive flag is low, so an undriven bus never floats. An asynchronous reset clears both storage elements and both keepers to zero. Reset also forces both drive flags low, whatever the enable inputs are.

Top module: `bus_xcvr18`

## Requirements
- R1: While `le_ab` is 1, the A-to-B path value equals `a_in` at once, with no edge on `clk_ab` needed. `b_out` shows that value whenever `b_drv` is 1.
- R2: While `le_ab` is 0 and `clk_ab` does not rise, the A-to-B stored word stays fixed whatever `a_in` does. A falling edge of `le_ab` keeps the `a_in` value present at that moment.
- R3: While `le_ab` is 0, each rising edge of `clk_ab` loads `a_in` into the A-to-B store. The new value appears on `b_out` right after that edge, and not before it.
- R4: `b_drv` equals `oe_ab`, which is active high, whenever `rst` is 0.
- R5: The B-to-A path follows the same transparent, hold and capture rules as R1 to R3, using `le_ba`, `clk_ba`, `b_in` and `a_out`.
- R6: `a_drv` equals the inverse of `oe_ba_n`, which is active low, whenever `rst` is 0.
- R7: While a drive flag is 0, the matching output keeps the last value that was driven on it. This holds even when the path's input, latch enable or clock changes.
- R8: While `rst` is 1, both drive flags are 0 and both outputs read 0, even if the enables request driving. After reset, both stores read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous reset, active high |
| clk_ab | input | 1 | A-to-B capture clock, rising edge |
| le_ab | input | 1 | A-to-B latch enable; 1 = transparent |
| oe_ab | input | 1 | A-to-B output enable, active high |
| a_in | input | 18 | Word on the A bus as seen by the block |
| b_out | output | 18 | Value on the B bus (driven value or kept value) |
| b_drv | output | 1 | 1 = block drives the B bus; 0 = high impedance |
| clk_ba | input | 1 | B-to-A capture clock, rising edge |
| le_ba | input | 1 | B-to-A latch enable; 1 = transparent |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_in | input | 18 | Word on the B bus as seen by the block |
| a_out | output | 18 | Value on the A bus (driven value or kept value) |
| a_drv | output | 1 | 1 = block drives the A bus; 0 = high impedance |

## Verification
The assertions sample each path on that path's own clock. They assume three things about the inputs:

- Data inputs change only away from the rising clock edges.
- A latch enable does not pulse high and back low between two clock edges while data is moving.
- A drive flag does not switch off in the same interval as a data change.

The bench keeps within these limits. It makes every change a couple of nanoseconds after a falling reference edge. It gates each path clock on only for the capture and keeper scenarios, and it runs the latch-enable sequence transparent, then hold, then capture, with no clock edges in between.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned XCVR_W = 18;

  // Output enable resolution: active level chosen per path, reset forces off.
  function automatic logic oe_active(input logic oe, input logic active_high, input logic rst);
    oe_active = !rst && (active_high ? oe : !oe);
  endfunction

  // Value presented by a path: the live input while transparent, else the store.
  function automatic logic [XCVR_W-1:0] path_value(input logic le,
                                                   input logic [XCVR_W-1:0] din,
                                                   input logic [XCVR_W-1:0] stored);
    path_value = le ? din : stored;
  endfunction
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 18
) (
  input  logic         rst,
  input  logic         clk,
  input  logic         le,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  // Loads on a rising clock while closed, and freezes the live input when
  // the latch enable falls; while open the path bypasses this store.
  always_ff @(posedge clk or negedge le or posedge rst) begin
    if (rst)
      q <= '0;
    else if (!le)
      q <= din;
  end
endmodule

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int unsigned W = 18
) (
  input  logic         rst,
  input  logic         drv,
  input  logic [W-1:0] val,
  output logic [W-1:0] y
);
  logic [W-1:0] kept;

  always_latch begin
    if (rst)
      kept = '0;
    else if (drv)
      kept = val;
  end

  assign y = drv ? val : kept;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W       = XCVR_W,
  parameter bit          OE_HIGH = 1'b1
) (
  input  logic         rst,
  input  logic         clk,
  input  logic         le,
  input  logic         oe,
  input  logic [W-1:0] din,
  output logic [W-1:0] stored,
  output logic [W-1:0] bus_out,
  output logic         drv
);
  logic [W-1:0] pval;

  xcvr_store #(.W(W)) u_store (
    .rst (rst),
    .clk (clk),
    .le  (le),
    .din (din),
    .q   (stored)
  );

  generate
    if (W == XCVR_W) begin : g_fn
      assign pval = path_value(le, din, stored);
    end else begin : g_mux
      assign pval = le ? din : stored;
    end
  endgenerate

  assign drv = oe_active(oe, OE_HIGH, rst);

  bus_keeper #(.W(W)) u_keep (
    .rst (rst),
    .drv (drv),
    .val (pval),
    .y   (bus_out)
  );
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         rst,
  input  logic         clk_ab,
  input  logic         le_ab,
  input  logic         oe_ab,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         clk_ba,
  input  logic         le_ba,
  input  logic         oe_ba_n,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_drv
);
  logic [W-1:0] ab_store;
  logic [W-1:0] ba_store;

  xcvr_path #(.W(W), .OE_HIGH(1'b1)) u_ab (
    .rst     (rst),
    .clk     (clk_ab),
    .le      (le_ab),
    .oe      (oe_ab),
    .din     (a_in),
    .stored  (ab_store),
    .bus_out (b_out),
    .drv     (b_drv)
  );

  xcvr_path #(.W(W), .OE_HIGH(1'b0)) u_ba (
    .rst     (rst),
    .clk     (clk_ba),
    .le      (le_ba),
    .oe      (oe_ba_n),
    .din     (b_in),
    .stored  (ba_store),
    .bus_out (a_out),
    .drv     (a_drv)
  );
endmodule

// File: rtl/bus_xcvr18_chk.sv
module bus_xcvr18_chk #(
  parameter int unsigned W = 18
) (
  input logic         rst,
  input logic         clk_ab,
  input logic         le_ab,
  input logic         oe_ab,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_out,
  input logic         b_drv,
  input logic         clk_ba,
  input logic         le_ba,
  input logic         oe_ba_n,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic [W-1:0] ab_store,
  input logic [W-1:0] ba_store
);
  logic ab_seen;
  logic ba_seen;

  always_ff @(posedge clk_ab or posedge rst)
    if (rst) ab_seen <= 1'b0; else ab_seen <= 1'b1;

  always_ff @(posedge clk_ba or posedge rst)
    if (rst) ba_seen <= 1'b0; else ba_seen <= 1'b1;

  // R1
  ab_transparent_chk: assert property (@(posedge clk_ab) disable iff (rst)
    (le_ab && oe_ab) |-> (b_out == a_in));

  // R3
  ab_capture_chk: assert property (@(posedge clk_ab) disable iff (rst)
    (ab_seen && !le_ab && $past(!le_ab)) |-> (ab_store == $past(a_in)));

  // R5
  ba_capture_chk: assert property (@(posedge clk_ba) disable iff (rst)
    (ba_seen && !le_ba && $past(!le_ba)) |-> (ba_store == $past(b_in)));

  // R4
  ab_enable_chk: assert property (@(posedge clk_ab) disable iff (rst)
    b_drv == oe_ab);

  // R6
  ba_enable_chk: assert property (@(posedge clk_ba) disable iff (rst)
    a_drv == !oe_ba_n);

  // R7
  b_keep_chk: assert property (@(posedge clk_ab) disable iff (rst)
    (ab_seen && !b_drv && $past(!b_drv)) |-> $stable(b_out));

  // R7
  a_keep_chk: assert property (@(posedge clk_ba) disable iff (rst)
    (ba_seen && !a_drv && $past(!a_drv)) |-> $stable(a_out));

  // R8
  always_comb begin
    if (rst === 1'b1) begin
      reset_off_chk: assert (!a_drv && !b_drv);
    end
  end
endmodule

bind bus_xcvr18 bus_xcvr18_chk #(.W(W)) u_chk (
  .rst      (rst),
  .clk_ab   (clk_ab),
  .le_ab    (le_ab),
  .oe_ab    (oe_ab),
  .a_in     (a_in),
  .b_out    (b_out),
  .b_drv    (b_drv),
  .clk_ba   (clk_ba),
  .le_ba    (le_ba),
  .oe_ba_n  (oe_ba_n),
  .b_in     (b_in),
  .a_out    (a_out),
  .a_drv    (a_drv),
  .ab_store (ab_store),
  .ba_store (ba_store)
);

// File: tb/tb_bus_xcvr18.sv
`timescale 1ns/1ps
module tb_bus_xcvr18;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic en_ab, en_ba;
  logic clk_ab, clk_ba;
  logic le_ab, oe_ab, le_ba, oe_ba_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_drv, b_drv;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign clk_ab = clk & en_ab;
  assign clk_ba = clk & en_ba;

  bus_xcvr18 #(.W(W)) dut (
    .rst(rst), .clk_ab(clk_ab), .le_ab(le_ab), .oe_ab(oe_ab), .a_in(a_in),
    .b_out(b_out), .b_drv(b_drv), .clk_ba(clk_ba), .le_ba(le_ba),
    .oe_ba_n(oe_ba_n), .b_in(b_in), .a_out(a_out), .a_drv(a_drv)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic t_reset();
    rst = 1'b1; oe_ab = 1'b1; oe_ba_n = 1'b0;
    step();
    chk("R8 b_drv", {17'd0, b_drv}, '0);
    chk("R8 a_drv", {17'd0, a_drv}, '0);
    oe_ab = 1'b0; oe_ba_n = 1'b1;
    step();
    rst = 1'b0;
    step();
    chk("R8 b_out", b_out, '0);
    chk("R8 a_out", a_out, '0);
    oe_ab = 1'b1; oe_ba_n = 1'b0; le_ab = 1'b0; le_ba = 1'b0;
    #1;
    chk("R8 ab store", b_out, '0);
    chk("R8 ba store", a_out, '0);
  endtask

  task automatic t_ab_transparent();
    le_ab = 1'b1; a_in = 18'h2A5A5; #1;
    chk("R1 pass", b_out, 18'h2A5A5);
    chk("R4 b_drv high", {17'd0, b_drv}, 18'd1);
    a_in = 18'h1C3F0; #1;
    chk("R1 pass 2", b_out, 18'h1C3F0);
  endtask

  task automatic t_ab_hold();
    le_ab = 1'b0; #1;
    a_in = 18'h00FFF; step();
    chk("R2 hold after le fall", b_out, 18'h1C3F0);
    a_in = 18'h3FFFF; step();
    chk("R2 hold static clock", b_out, 18'h1C3F0);
  endtask

  task automatic t_ab_capture();
    en_ab = 1'b1; a_in = 18'h12345; #1;
    chk("R3 not before edge", b_out, 18'h1C3F0);
    @(posedge clk); #2;
    chk("R3 loaded on edge", b_out, 18'h12345);
    step(); a_in = 18'h0BEEF; step();
    chk("R3 second capture", b_out, 18'h0BEEF);
  endtask

  task automatic t_ab_keep();
    oe_ab = 1'b0; #1;
    chk("R4 b_drv low", {17'd0, b_drv}, '0);
    chk("R7 b keep", b_out, 18'h0BEEF);
    a_in = 18'h15555; step(); step();
    chk("R7 b keep after clocks", b_out, 18'h0BEEF);
    en_ab = 1'b0;
  endtask

  task automatic t_ba_transparent();
    le_ba = 1'b1; b_in = 18'h3C3C3; #1;
    chk("R5 pass", a_out, 18'h3C3C3);
    chk("R6 a_drv high", {17'd0, a_drv}, 18'd1);
    b_in = 18'h00001; #1;
    chk("R5 pass 2", a_out, 18'h00001);
  endtask

  task automatic t_ba_hold();
    le_ba = 1'b0; #1;
    b_in = 18'h2AAAA; step();
    chk("R5 hold", a_out, 18'h00001);
  endtask

  task automatic t_ba_capture();
    en_ba = 1'b1; b_in = 18'h0F0F0; #1;
    chk("R5 not before edge", a_out, 18'h00001);
    @(posedge clk); #2;
    chk("R5 loaded on edge", a_out, 18'h0F0F0);
  endtask

  task automatic t_ba_keep();
    step();
    oe_ba_n = 1'b1; #1;
    chk("R6 a_drv low", {17'd0, a_drv}, '0);
    chk("R7 a keep", a_out, 18'h0F0F0);
    b_in = 18'h3FFFF; step(); step();
    chk("R7 a keep after clocks", a_out, 18'h0F0F0);
    en_ba = 1'b0;
  endtask

  initial begin
    en_ab = 1'b0; en_ba = 1'b0; rst = 1'b1;
    le_ab = 1'b0; le_ba = 1'b0; oe_ab = 1'b0; oe_ba_n = 1'b1;
    a_in = '0; b_in = '0;
    t_reset();
    t_ab_transparent();
    t_ab_hold();
    t_ab_capture();
    t_ab_keep();
    t_ba_transparent();
    t_ba_hold();
    t_ba_capture();
    t_ba_keep();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule